// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an 8-pin general-purpose I/O port on a plain memory-mapped register bus. The bus has an address, a write enable, write data and combinational read data. The port has no fixed data register. Instead, address bits [9:2] of an access to the data window act as a per-pin mask. A write changes only the pins whose mask bit is set. A read returns only the masked pin levels, with every other bit forced to zero. Software can therefore drive one pin high or low with a single store and never has to read, modify and write the register.

A separate direction register at byte offset 0x400 sets each pin as an output or an input. For an output pin, the level that is read back is the driven output register bit. For an input pin, it is the pad input after a two-flop synchronizer. Software must not assume that all input pins idle at the same polarity. Every access completes in the cycle it is presented, with no wait states.

Top module: `gpio_masked_port`

## Requirements
- R1: While reset is asserted, the direction register, the output register and all output enables are 0 (every pin is an input and drives low).
- R2: A write with address bits [11:10] = 0 and [1:0] = 0 is a data write. Each pin whose address bit (pin index + 2) is 1 takes the write-data bit at the pin's index. All other pins keep their output register value.
- R3: Writing (1 << X) at byte offset (1 << (X+2)) drives pin X high, and writing 0 there drives it low. Other pins are unaffected (for example, pin 7 is at 0x200 and pin 6 at 0x100).
- R4: A write to offset 0x400 loads the direction register from write data. Bit X = 1 makes pin X an output, and pad_oe[X] follows it from the next cycle.
- R5: A read of offset 0x400 returns the direction register.
- R6: A data-window read returns the pin levels ANDed with the address mask. Bits outside the mask read 0, and a mask of several bits returns several pins at once.
- R7: The read level of an output pin is its output register bit. The read level of an input pin is pad_in after exactly two rising clock edges of synchronization.
- R8: A data-window access with mask 0 (offset 0x000) changes no pin on a write and returns 0 on a read.
- R9: A write to any other address, such as 0x404, 0x800 or 0x001, changes no register, and a read of such an address returns 0.
- R10: pad_out always shows the output register, so a data write to a pin configured as input still updates its stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data, one bit per pin |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| pad_out | output | 8 | Output register value driven to the pads |
| pad_oe | output | 8 | Output enable per pin (1 = drive) |
| pad_in | input | 8 | Raw asynchronous pad inputs |

## Verification
The properties assume that bus_addr, bus_we and bus_wdata are stable around each rising edge. They also assume the read data is meaningful only for the address currently presented. The stimulus changes all bus inputs on the falling edge to keep within this. Because pad_in may change at any time, the read-path property covers only pins that are configured as outputs. The bench checks input-pin reads only after the synchronizer has had two edges to settle, or exactly at those two edges when the latency itself is being measured.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Which register window a bus address falls into.
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_DATA = 2'd1,
    WIN_DIR  = 2'd2
  } gpio_win_e;

  // Byte offset of the direction register for a port of npins pins.
  function automatic int unsigned dir_offset(input int unsigned npins);
    return 32'd1 << (npins + 2);
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output gpio_win_e         win,
  output logic [NPINS-1:0]  pin_mask
);

  localparam int unsigned MASK_LO = 2;
  localparam int unsigned MASK_HI = NPINS + 1;
  localparam int unsigned HI_W    = ADDR_W - NPINS - 2;
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(dir_offset(NPINS));

  logic upper_clear;
  logic lanes_clear;

  assign upper_clear = (addr[ADDR_W-1:MASK_HI+1] == {HI_W{1'b0}});
  assign lanes_clear = (addr[MASK_LO-1:0] == 2'b00);

  always_comb begin
    if (addr == DIR_ADDR) begin
      win = WIN_DIR;
    end else if (upper_clear && lanes_clear) begin
      win = WIN_DATA;
    end else begin
      win = WIN_NONE;
    end
  end

  // The mask is meaningful only in the data window; zero it elsewhere.
  assign pin_mask = (win == WIN_DATA) ? addr[MASK_HI:MASK_LO] : '0;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] raw_in,
  output logic [NPINS-1:0] sync_out
);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], raw_in[p]};
      end
    end

    assign sync_out[p] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  gpio_win_e        win,
  input  logic [NPINS-1:0] pin_mask,
  input  logic [NPINS-1:0] wr_data,
  input  logic [NPINS-1:0] in_sync,
  output logic [NPINS-1:0] out_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] level
);

  logic dir_wr;
  logic data_wr;

  assign dir_wr  = wr_en && (win == WIN_DIR);
  assign data_wr = wr_en && (win == WIN_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_wr) begin
      dir_q <= wr_data;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q[p] <= 1'b0;
      end else if (data_wr && pin_mask[p]) begin
        out_q[p] <= wr_data[p];
      end
    end

    // Read level: own driven value for outputs, synchronized pad for inputs.
    assign level[p] = dir_q[p] ? out_q[p] : in_sync[p];
  end

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  input  logic [NPINS-1:0]  pad_in
);

  gpio_win_e        win;
  logic [NPINS-1:0] pin_mask;
  logic [NPINS-1:0] in_sync;
  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] level;

  gpio_addr_decode #(
    .NPINS (NPINS),
    .ADDR_W(ADDR_W)
  ) u_dec (
    .addr    (bus_addr),
    .win     (win),
    .pin_mask(pin_mask)
  );

  gpio_in_sync #(
    .NPINS (NPINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_in  (pad_in),
    .sync_out(in_sync)
  );

  gpio_port_regs #(
    .NPINS(NPINS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_we),
    .win     (win),
    .pin_mask(pin_mask),
    .wr_data (bus_wdata),
    .in_sync (in_sync),
    .out_q   (out_q),
    .dir_q   (dir_q),
    .level   (level)
  );

  always_comb begin
    unique case (win)
      WIN_DATA: bus_rdata = level & pin_mask;
      WIN_DIR:  bus_rdata = dir_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe
);

  localparam logic [ADDR_W-1:0] DIR_AT = ADDR_W'(1) << (NPINS + 2);

  logic             in_data;
  logic             in_dir;
  logic             in_other;
  logic [NPINS-1:0] msk;

  always_comb begin
    in_dir   = (bus_addr == DIR_AT);
    in_data  = ((bus_addr >> (NPINS + 2)) == '0) && (bus_addr[1:0] == 2'b00);
    in_other = !in_dir && !in_data;
    msk      = bus_addr[NPINS+1:2];
  end

  // R1: reset clears pins to undriven inputs with low output register
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && pad_out == '0));

  // R2: masked pins take write data
  a_r2_masked_take: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && in_data) |=>
      ((pad_out & $past(msk)) == ($past(bus_wdata) & $past(msk))));

  // R2: unmasked pins hold
  a_r2_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && in_data) |=>
      ((pad_out & ~$past(msk)) == ($past(pad_out) & ~$past(msk))));

  // R4: direction write lands on the enables
  a_r4_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && in_dir) |=> (pad_oe == $past(bus_wdata)));

  // R5: direction readback
  a_r5_dir_read: assert property (@(posedge clk) disable iff (!rst_n)
    in_dir |-> (bus_rdata == pad_oe));

  // R6: bits outside the mask read zero
  a_r6_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> ((bus_rdata & ~msk) == '0));

  // R7: output pins read their driven value
  a_r7_out_readback: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> ((bus_rdata & msk & pad_oe) == (pad_out & msk & pad_oe)));

  // R9: stray writes change nothing
  a_r9_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && in_other) |=> ($stable(pad_out) && $stable(pad_oe)));

  // R9: stray reads return zero
  a_r9_stray_read: assert property (@(posedge clk) disable iff (!rst_n)
    in_other |-> (bus_rdata == '0));

endmodule

bind gpio_masked_port gpio_masked_port_chk #(
  .NPINS (NPINS),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe)
);

// File: tb/tb_gpio_masked_port.sv
`timescale 1ns/100ps
module tb_gpio_masked_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;
  logic [7:0]  pad_in = 8'hA5;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_masked_port dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_in   (pad_in)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [7:0]  wd;
    logic [7:0]  rd;   // read data seen before the edge
    logic [7:0]  po;   // pad_out after the edge
    logic [7:0]  oe;   // pad_oe after the edge
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  // pad_in is held at 8'hA5 throughout the table.
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h3FC, 8'h00, 8'hA5, 8'h00, 8'h00, 8'd6},  // R6 full mask, all inputs
    '{1'b0, 12'h00C, 8'h00, 8'h01, 8'h00, 8'h00, 8'd6},  // R6 two-pin mask
    '{1'b0, 12'h000, 8'h00, 8'h00, 8'h00, 8'h00, 8'd8},  // R8 zero mask read
    '{1'b1, 12'h400, 8'hF0, 8'h00, 8'h00, 8'hF0, 8'd4},  // R4 upper nibble out
    '{1'b0, 12'h400, 8'h00, 8'hF0, 8'h00, 8'hF0, 8'd5},  // R5 readback
    '{1'b0, 12'h3FC, 8'h00, 8'h05, 8'h00, 8'hF0, 8'd7},  // R7 mixed levels
    '{1'b1, 12'h200, 8'h80, 8'h00, 8'h80, 8'hF0, 8'd3},  // R3 set pin 7
    '{1'b1, 12'h3C0, 8'h5A, 8'h80, 8'h50, 8'hF0, 8'd2},  // R2 upper-nibble mask
    '{1'b0, 12'h3FC, 8'h00, 8'h55, 8'h50, 8'hF0, 8'd6},  // R6
    '{1'b1, 12'h100, 8'h00, 8'h40, 8'h10, 8'hF0, 8'd3},  // R3 clear pin 6
    '{1'b1, 12'h000, 8'hFF, 8'h00, 8'h10, 8'hF0, 8'd8},  // R8 zero mask write
    '{1'b1, 12'h404, 8'hFF, 8'h00, 8'h10, 8'hF0, 8'd9},  // R9
    '{1'b1, 12'h800, 8'hFF, 8'h00, 8'h10, 8'hF0, 8'd9},  // R9
    '{1'b1, 12'h001, 8'hFF, 8'h00, 8'h10, 8'hF0, 8'd9},  // R9 misaligned
    '{1'b0, 12'h0F0, 8'h00, 8'h14, 8'h10, 8'hF0, 8'd6},  // R6 middle mask
    '{1'b1, 12'h008, 8'h02, 8'h00, 8'h12, 8'hF0, 8'd10}, // R10 write input pin
    '{1'b1, 12'h400, 8'h0F, 8'hF0, 8'h12, 8'h0F, 8'd4},  // R4 swap direction
    '{1'b0, 12'h3FC, 8'h00, 8'hA2, 8'h12, 8'h0F, 8'd7}   // R7
  };

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic bus_idle();
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "pad_oe in reset", pad_oe, 8'h00);
    check("R1", "pad_out in reset", pad_out, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    bus_addr = 12'h400;
    #1;
    check("R1", "dir readback after reset", bus_rdata, 8'h00);
    repeat (3) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      @(negedge clk);
      bus_we = VECS[i].wr; bus_addr = VECS[i].addr; bus_wdata = VECS[i].wd;
      #1;
      check(tag, "bus_rdata", bus_rdata, VECS[i].rd);
      @(posedge clk);
      #1;
      bus_we = 1'b0;
      check(tag, "pad_out", pad_out, VECS[i].po);
      check(tag, "pad_oe", pad_oe, VECS[i].oe);
    end

    // R7: two-edge synchronizer latency; dir = 0F, out = 12.
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 12'h3FC;
    pad_in = 8'h5A;
    #1;
    check("R7", "rdata before edges", bus_rdata, 8'hA2);
    @(posedge clk); #1;
    check("R7", "rdata after one edge", bus_rdata, 8'hA2);
    @(posedge clk); #1;
    check("R7", "rdata after two edges", bus_rdata, 8'h52);

    // R3: clear and set via single-pin offsets on an output pin
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 12'h008; bus_wdata = 8'h00;
    @(posedge clk); #1;
    check("R3", "pin1 cleared", pad_out, 8'h10);
    bus_idle();

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    #1;
    check("R1", "pad_oe async reset", pad_oe, 8'h00);
    check("R1", "pad_out async reset", pad_out, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    bus_addr = 12'h400;
    #1;
    check("R5", "dir after second reset", bus_rdata, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule